// File: doc/BRIEF.md
# Cache Tag Store with Match and Acknowledge

This block keeps the tags of a direct-mapped secondary cache. Every entry holds a 12-bit tag and three status bits. The status bits mean valid, dirty and write-through, or they are free user bits, depending on a mode input. The stored tag at the addressed entry is compared with the tag presented on the input, and a match flag comes out in the same cycle. The stored tag and status also come back on read-data buses in that same cycle, with no clock involved. Tag and status writes take effect at the rising clock edge. Each field has its own write enable.

A synchronous, active-low clear invalidates the whole array in one edge. The block also produces an active-low transfer acknowledge. It is built from the match result, the stored valid and write-through bits, the processor's read/write direction and an external acknowledge input. A hold input can force the acknowledge off. Two active-low chip selects must both be asserted for the block to respond. The read buses and the acknowledge each have their own output enable. Each output is modelled as a data value plus a drive flag instead of a tristate pad.

Top module: `tag_store`

## Requirements
- R1: When both chip selects are low and `tag_we_n` is low at a rising clock edge, the entry at `addr` takes `tag_in`. Read data reflects the new tag from the next cycle on.
- R2: `match` is high exactly when the block is selected, the stored tag at `addr` equals `tag_in`, and either generic mode is on or the stored valid bit is 1.
- R3: In built-in mode (`stat_generic` = 0), an entry whose valid bit is 0 never raises `match`.
- R4: A tag write leaves the status of every entry unchanged. A status write (`stat_we_n` low, selected) leaves every tag unchanged.
- R5: `clr_n` low at a rising edge clears all three status bits of every entry. This happens whether or not the block is selected. On the same edge a status write is overridden, but a tag write still stores its tag.
- R6: Status bit positions on `stat_in` and `stat_out` are bit 0 valid, bit 1 dirty and bit 2 write-through. In generic mode, all three bits are stored and read back as written, and they do not gate `match` or the acknowledge.
- R7: `ack_n` is low exactly when the block is selected, `ack_hold` is low, and either `ext_ack_n` is low or the access qualifies. In built-in mode an access qualifies when `match` is high and it is either a read (`rd_wr` = 1) or a write whose stored write-through bit is 0. In generic mode an access qualifies whenever `match` is high.
- R8: `ack_hold` high keeps `ack_n` high, whatever the other inputs are.
- R9: `tag_drv` = selected and `tag_oe_n` low and `tag_we_n` high. `stat_drv` follows the same rule with `stat_oe_n` and `stat_we_n`. `ack_drv` = selected and `ack_oe_n` low. A read bus reads zero while its drive flag is low.
- R10: While either chip select is high, no write happens, `match` is low and no drive flag is high.
- R11: `match`, `tag_out`, `stat_out` and `ack_n` follow changes on `addr` and `tag_in` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| clr_n | input | 1 | Synchronous clear of all status bits, active low |
| sel_a_n | input | 1 | Chip select A, active low |
| sel_b_n | input | 1 | Chip select B, active low |
| addr | input | ADDR_W | Entry index |
| tag_in | input | TAG_W | Tag to compare or write |
| stat_in | input | 3 | Status to write (0 valid, 1 dirty, 2 write-through) |
| tag_we_n | input | 1 | Tag write enable, active low |
| stat_we_n | input | 1 | Status write enable, active low |
| tag_oe_n | input | 1 | Tag read output enable, active low |
| stat_oe_n | input | 1 | Status read output enable, active low |
| ack_oe_n | input | 1 | Acknowledge output enable, active low |
| stat_generic | input | 1 | 1: status bits are plain user bits |
| rd_wr | input | 1 | Processor access direction, 1 = read |
| ext_ack_n | input | 1 | External acknowledge request, active low |
| ack_hold | input | 1 | Forces the acknowledge off |
| match | output | 1 | Tag compare hit |
| tag_out | output | TAG_W | Stored tag read data |
| tag_drv | output | 1 | Tag read bus driven |
| stat_out | output | 3 | Stored status read data |
| stat_drv | output | 1 | Status read bus driven |
| ack_n | output | 1 | Transfer acknowledge, active low |
| ack_drv | output | 1 | Acknowledge pin driven |

## Verification
On every cycle, the assertions check several properties. An entry never matches while it is invalid in built-in mode. A deselected block and a raised hold keep the acknowledge off. A clear edge leaves every status bit at zero. A tag write lands at the written index and does not disturb the valid bits. The assertions do not cover the finer behaviour. That includes the exact acknowledge qualification with write-through and direction, generic-mode read-back, the priority of clear over a status write on the same edge, and whether a deselected write left the array untouched. Only the bench's random and directed scenarios show these, by comparing the ports against a model of the array.

// File: rtl/tag_store.sv
module tag_store #(
  parameter int ADDR_W = 8,
  parameter int TAG_W  = 12
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              sel_a_n,
  input  logic              sel_b_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TAG_W-1:0]  tag_in,
  input  logic [2:0]        stat_in,
  input  logic              tag_we_n,
  input  logic              stat_we_n,
  input  logic              tag_oe_n,
  input  logic              stat_oe_n,
  input  logic              ack_oe_n,
  input  logic              stat_generic,
  input  logic              rd_wr,
  input  logic              ext_ack_n,
  input  logic              ack_hold,
  output logic              match,
  output logic [TAG_W-1:0]  tag_out,
  output logic              tag_drv,
  output logic [2:0]        stat_out,
  output logic              stat_drv,
  output logic              ack_n,
  output logic              ack_drv
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [DEPTH-1:0] vld_q, dty_q, wt_q;

  logic sel, hit_raw, vld, wt, qual;

  assign sel = ~sel_a_n & ~sel_b_n;
  assign vld = vld_q[addr];
  assign wt  = wt_q[addr];

  // tag field: written only under its own enable
  always_ff @(posedge clk)
    if (sel && !tag_we_n) tag_mem[addr] <= tag_in;

  // status field: the clear covers the whole array and outranks a write
  always_ff @(posedge clk) begin
    if (!clr_n) begin
      vld_q <= '0;
      dty_q <= '0;
      wt_q  <= '0;
    end else if (sel && !stat_we_n) begin
      vld_q[addr] <= stat_in[0];
      dty_q[addr] <= stat_in[1];
      wt_q[addr]  <= stat_in[2];
    end
  end

  assign hit_raw = (tag_mem[addr] == tag_in);
  assign match   = sel & hit_raw & (stat_generic | vld);
  assign qual    = stat_generic ? match : (match & (rd_wr | ~wt));
  assign ack_n   = ~(sel & ~ack_hold & (~ext_ack_n | qual));

  assign tag_drv  = sel & ~tag_oe_n & tag_we_n;
  assign stat_drv = sel & ~stat_oe_n & stat_we_n;
  assign ack_drv  = sel & ~ack_oe_n;
  assign tag_out  = tag_drv ? tag_mem[addr] : '0;
  assign stat_out = stat_drv ? {wt, dty_q[addr], vld} : 3'b000;

  assert_clear_all_R5: assert property (@(posedge clk)
    !clr_n |=> (vld_q == '0 && dty_q == '0 && wt_q == '0));

  assert_invalid_nohit_R3: assert property (@(posedge clk)
    (!stat_generic && !vld_q[addr]) |-> !match);

  assert_deselect_quiet_R10: assert property (@(posedge clk)
    (sel_a_n || sel_b_n) |-> (ack_n && !match && !tag_drv && !stat_drv && !ack_drv));

  assert_hold_blocks_R8: assert property (@(posedge clk)
    ack_hold |-> ack_n);

  assert_tag_lands_R1: assert property (@(posedge clk)
    (sel && !tag_we_n) |=> (tag_mem[$past(addr)] == $past(tag_in)));

  assert_tag_keeps_valid_R4: assert property (@(posedge clk)
    (sel && !tag_we_n && stat_we_n && clr_n) |=> (vld_q == $past(vld_q)));
endmodule

// File: tb/sim_tag_store.sv
module sim_tag_store;
  localparam int AW = 4;
  localparam int TW = 12;
  localparam int N  = 1 << AW;

  logic clk = 0;
  always #5 clk = ~clk;

  logic clr_n = 1, sel_a_n = 1, sel_b_n = 1;
  logic [AW-1:0] addr = '0;
  logic [TW-1:0] tag_in = '0;
  logic [2:0] stat_in = '0;
  logic tag_we_n = 1, stat_we_n = 1, tag_oe_n = 1, stat_oe_n = 1, ack_oe_n = 1;
  logic stat_generic = 0, rd_wr = 1, ext_ack_n = 1, ack_hold = 0;
  logic match, tag_drv, stat_drv, ack_n, ack_drv;
  logic [TW-1:0] tag_out;
  logic [2:0] stat_out;

  tag_store #(.ADDR_W(AW), .TAG_W(TW)) u0 (.*);

  logic [TW-1:0] mtag [N];
  logic [2:0]    mst  [N];
  int checks = 0, errors = 0;

  function automatic logic f_sel();
    return !sel_a_n && !sel_b_n;
  endfunction
  function automatic logic f_match();
    return f_sel() && mtag[addr] == tag_in && (stat_generic || mst[addr][0]);
  endfunction
  function automatic logic f_ack_n();
    logic q;
    q = stat_generic ? f_match() : (f_match() && (rd_wr || !mst[addr][2]));
    return !(f_sel() && !ack_hold && (!ext_ack_n || q));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic td, sd;
    td = f_sel() && !tag_oe_n && tag_we_n;
    sd = f_sel() && !stat_oe_n && stat_we_n;
    chk({tag, " R2 match"}, match, f_match());
    chk({tag, " R7 ack_n"}, ack_n, f_ack_n());
    chk({tag, " R9 tag_drv"}, tag_drv, td);
    chk({tag, " R9 stat_drv"}, stat_drv, sd);
    chk({tag, " R9 ack_drv"}, ack_drv, f_sel() && !ack_oe_n);
    chk({tag, " R1 tag_out"}, tag_out, td ? mtag[addr] : '0);
    chk({tag, " R6 stat_out"}, stat_out, sd ? mst[addr] : 3'b0);
  endtask

  task automatic step(string tag);
    #2;
    check_all(tag);
    @(posedge clk);
    if (f_sel() && !tag_we_n) mtag[addr] = tag_in;
    if (!clr_n) for (int i = 0; i < N; i++) mst[i] = 3'b0;
    else if (f_sel() && !stat_we_n) mst[addr] = stat_in;
    @(negedge clk);
  endtask

  task automatic idle();
    sel_a_n = 0; sel_b_n = 0; clr_n = 1; tag_we_n = 1; stat_we_n = 1;
    tag_oe_n = 0; stat_oe_n = 0; ack_oe_n = 0; ack_hold = 0; ext_ack_n = 1;
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin mtag[i] = '0; mst[i] = 3'b0; end
    @(negedge clk);
    idle();
    // R5: clear, then write every tag (R1, R4) and check status stays zero
    clr_n = 0; step("init-clear R5"); clr_n = 1;
    for (int i = 0; i < N; i++) begin
      addr = i[AW-1:0]; tag_in = TW'(i * 37 + 5); tag_we_n = 0; step("init R1");
    end
    tag_we_n = 1;
    // R3: valid clear, tag equal -> no match in built-in mode; R11 same-cycle
    addr = 3; tag_in = mtag[3]; step("R3 invalid");
    chk("R3 invalid nohit", match, 1'b0);
    stat_generic = 1; #1 chk("R6 generic ignores valid", match, 1'b1);
    addr = 4; tag_in = mtag[4]; #1 chk("R11 comb follow", match, 1'b1);
    stat_generic = 0;
    // R5: clear beats status write, tag write survives
    addr = 6; stat_in = 3'b111; stat_we_n = 0; step("set st");
    stat_we_n = 0; tag_we_n = 0; clr_n = 0; tag_in = 12'hABC; step("R5 same edge");
    idle(); addr = 6; tag_in = 12'hABC; #1;
    chk("R5 status cleared", stat_out, 3'b000);
    chk("R5 tag still written", tag_out, 12'hABC);
    // R7: write with write-through set does not qualify, read does
    stat_in = 3'b101; stat_we_n = 0; step("wt set"); stat_we_n = 1;
    rd_wr = 0; #1 chk("R7 write wt no ack", ack_n, 1'b1);
    rd_wr = 1; #1 chk("R7 read ack", ack_n, 1'b0);
    ack_hold = 1; #1 chk("R8 hold", ack_n, 1'b1);
    ack_hold = 0; ext_ack_n = 0; tag_in = 12'h000; #1 chk("R7 external ack", ack_n, 1'b0);
    ext_ack_n = 1;
    // R10: deselected write has no effect
    sel_b_n = 1; tag_we_n = 0; stat_we_n = 0; tag_in = 12'h555; stat_in = 3'b010;
    step("R10 deselected");
    idle(); tag_in = 12'h555; #1;
    chk("R10 tag kept", tag_out, 12'hABC);
    chk("R10 status kept", stat_out, 3'b101);
    // random phase
    for (int k = 0; k < 3000; k++) begin
      addr = AW'($urandom);
      sel_a_n = ($urandom % 8) == 0;
      sel_b_n = ($urandom % 8) == 0;
      tag_in = ($urandom % 2) ? mtag[addr] : TW'($urandom);
      stat_in = 3'($urandom);
      tag_we_n = ($urandom % 4) != 0;
      stat_we_n = ($urandom % 4) != 0;
      tag_oe_n = ($urandom % 4) == 0;
      stat_oe_n = ($urandom % 4) == 0;
      ack_oe_n = ($urandom % 4) == 0;
      stat_generic = ($urandom % 4) == 0;
      rd_wr = 1'($urandom);
      ext_ack_n = ($urandom % 6) != 0;
      ack_hold = ($urandom % 8) == 0;
      clr_n = ($urandom % 40) != 0;
      step("random R4");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule